// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Line-Break Detection

This block receives characters from an asynchronous serial line that rests high. A tick generator divides the system clock by a run-time divisor to produce a sampling tick at sixteen times the bit rate. The receiver watches the synchronized line on those ticks. A falling level marks a candidate start bit. The candidate is confirmed at the middle of the start bit, and every later bit is then read once at its centre. Characters of five to eight data bits are assembled with the least significant bit first. An optional even or odd parity bit and the first stop bit are checked.

A line held low through the data bits, the parity bit and the stop slot, and still low just past the end of the frame, is a break. A break is reported once, with zero data, and the receiver then waits for the line to go high before it looks for a new start. Each finished character is presented for exactly one clock on a valid strobe, and its error flags are valid in that same clock.

Top module: `serial_rx_brk`

## Requirements
- R1: After reset, rx_valid, rx_par_err, rx_frm_err and rx_break are all 0, and no character is reported while the line stays high.
- R2: A low level on an idle line starts a character only if it is still low at the middle of the start bit, on the 8th sampling tick. A shorter low pulse produces no character, and a later well-formed frame is still received.
- R3: The data width is 5 + len_sel bits (len_sel 0..3 gives 5..8). Bits are assembled least significant bit first, and rx_data bits at or above the width read 0.
- R4: When par_en is 1, one parity bit follows the data. With par_odd = 0 the data bits plus parity must hold an even number of ones, and with par_odd = 1 an odd number. A mismatch sets rx_par_err with the character. When par_en is 0, no parity bit is expected and rx_par_err stays 0.
- R5: A low first stop bit, where the frame is not all-zero, sets rx_frm_err with the received data. The receiver then waits for the line to go high before it accepts a new start.
- R6: If start, data, parity and first stop are all low and the line is still low one sampling tick past the end of the stop slot (the second stop slot when two are configured), one character is reported with rx_break = 1, rx_data = 0 and the other flags 0. No further character is reported until the line has returned high. If the line rises before that point, the character is reported instead with rx_frm_err = 1 and rx_data = 0.
- R7: rx_valid is high for exactly one clock per character, and the error flags are never high while rx_valid is low.
- R8: With stop_two = 1, only the first stop bit is checked. A low second stop bit raises no flag and is not taken as a new start bit.
- R9: The sampling tick period is max(baud_div, 1) clocks, so one bit lasts 16 × max(baud_div, 1) clocks. A divisor of 0 behaves like 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | 12 | Clocks per sampling tick (0 is treated as 1) |
| len_sel | input | 2 | Data width select, width = 5 + len_sel |
| par_en | input | 1 | Expect a parity bit after the data |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_two | input | 1 | Frame carries two stop bits |
| rx_line | input | 1 | Serial input, idle high |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-clock strobe for each character |
| rx_par_err | output | 1 | Parity mismatch, valid with rx_valid |
| rx_frm_err | output | 1 | Low first stop bit, valid with rx_valid |
| rx_break | output | 1 | Line-break report, valid with rx_valid |

## Verification
A parity mismatch and a framing error can both belong to one character and appear in the same valid cycle. The bench sends frames with a deliberately wrong parity bit and a low stop bit, and expects both flags together. The break decision also competes with the framing decision in one window just past the stop slot. A low run of exactly ten bit times must resolve to a framing error with zero data, while a fourteen-bit low run must resolve to a single break report. Both outcomes are judged by the flag values and by the total count of valid strobes seen.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRKW,
      ST_STOP2,
      ST_WAITHI
   } srx_state_e;

   function automatic logic par_expect(input logic ones_xor, input logic odd_mode);
      return ones_xor ^ odd_mode;
   endfunction

endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   generate
      if (DIV_W < 1) begin : g_bad_div_w
         $error("srx_tick_gen: DIV_W must be at least 1");
      end
   endgenerate

   always_comb begin
      lim = (div == '0) ? '0 : div - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= lim) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

   // R9: with a divisor above one, ticks never come back to back
   p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && lim != '0) |=> (!tick || !$stable(div)));

endmodule

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("srx_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} & {STAGES{1'b1}};
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
   import srx_pkg::*;
#(
   parameter int OVS      = 16,
   parameter int DATA_MAX = 8,
   parameter int LEN_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rx_s,
   input  logic [LEN_W-1:0]    len_sel,
   input  logic                par_en,
   input  logic                par_odd,
   input  logic                stop_two,
   output logic [DATA_MAX-1:0] data,
   output logic                valid,
   output logic                par_err,
   output logic                frm_err,
   output logic                brk
);

   localparam int HALF     = OVS / 2;
   localparam int CNT_W    = $clog2(2 * OVS);
   localparam int BIDX_W   = (DATA_MAX > 1) ? $clog2(DATA_MAX) : 1;
   localparam int MIN_BITS = DATA_MAX - (1 << LEN_W) + 1;

   localparam logic [CNT_W-1:0] START_MID = CNT_W'(HALF - 1);
   localparam logic [CNT_W-1:0] BIT_END   = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] STOP2_END = CNT_W'(OVS + HALF - 1);
   localparam logic [CNT_W-1:0] BRK_ONE   = CNT_W'(HALF);
   localparam logic [CNT_W-1:0] BRK_TWO   = CNT_W'(OVS + HALF);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("srx_frame_fsm: OVS must be even and at least 4");
      end
      if (MIN_BITS < 1) begin : g_bad_len
         $error("srx_frame_fsm: LEN_W too wide for DATA_MAX");
      end
   endgenerate

   srx_state_e          state;
   logic [CNT_W-1:0]    cnt;
   logic [BIDX_W-1:0]   bidx;
   logic [DATA_MAX-1:0] shreg;
   logic                ones;
   logic                allz;
   logic                par_rx;

   int                  nbits;
   logic [BIDX_W-1:0]   last_bit;
   logic [DATA_MAX-1:0] aligned;
   logic                par_bad;
   logic [CNT_W-1:0]    brk_lim;

   always_comb begin
      nbits    = MIN_BITS + int'(len_sel);
      last_bit = BIDX_W'(nbits - 1);
      aligned  = shreg >> (DATA_MAX - nbits);
      par_bad  = par_en && (par_rx != par_expect(ones, par_odd));
      brk_lim  = stop_two ? BRK_TWO : BRK_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bidx    <= '0;
         shreg   <= '0;
         ones    <= 1'b0;
         allz    <= 1'b1;
         par_rx  <= 1'b0;
         valid   <= 1'b0;
         data    <= '0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
         brk     <= 1'b0;
      end else begin
         valid   <= 1'b0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
         brk     <= 1'b0;
         if (tick) begin
            case (state)
               ST_IDLE: begin
                  if (!rx_s) begin
                     state <= ST_START;
                     cnt   <= '0;
                  end
               end
               ST_START: begin
                  if (cnt == START_MID) begin
                     cnt   <= '0;
                     bidx  <= '0;
                     shreg <= '0;
                     ones  <= 1'b0;
                     allz  <= 1'b1;
                     state <= rx_s ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (cnt == BIT_END) begin
                     cnt   <= '0;
                     shreg <= {rx_s, shreg[DATA_MAX-1:1]};
                     ones  <= ones ^ rx_s;
                     allz  <= allz & ~rx_s;
                     if (bidx == last_bit) state <= par_en ? ST_PAR : ST_STOP;
                     else                  bidx  <= bidx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (cnt == BIT_END) begin
                     cnt    <= '0;
                     par_rx <= rx_s;
                     allz   <= allz & ~rx_s;
                     state  <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt == BIT_END) begin
                     cnt <= '0;
                     if (rx_s) begin
                        valid   <= 1'b1;
                        data    <= aligned;
                        par_err <= par_bad;
                        state   <= stop_two ? ST_STOP2 : ST_IDLE;
                     end else if (allz) begin
                        state <= ST_BRKW;
                     end else begin
                        valid   <= 1'b1;
                        data    <= aligned;
                        par_err <= par_bad;
                        frm_err <= 1'b1;
                        state   <= ST_WAITHI;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_BRKW: begin
                  if (rx_s) begin
                     valid   <= 1'b1;
                     data    <= '0;
                     par_err <= par_bad;
                     frm_err <= 1'b1;
                     cnt     <= '0;
                     state   <= ST_IDLE;
                  end else if (cnt == brk_lim) begin
                     valid <= 1'b1;
                     data  <= '0;
                     brk   <= 1'b1;
                     cnt   <= '0;
                     state <= ST_WAITHI;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP2: begin
                  if (cnt == STOP2_END) begin
                     cnt   <= '0;
                     state <= ST_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_WAITHI: begin
                  if (rx_s) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R7: one-clock strobe per character
   p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R7: flags appear only together with the strobe
   p_flags_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err || frm_err || brk) |-> valid);

   // R6: a break carries zero data and no other flag
   p_brk_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      brk |-> (data == '0 && !frm_err && !par_err));

   // R6: no new start while the line remains low after a break or framing error
   p_waithi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAITHI && !rx_s) |=> (state == ST_WAITHI));

   // R2: a start that is high again at its midpoint is dropped
   p_glitch_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && tick && cnt == START_MID && rx_s) |=> (state == ST_IDLE));

   // R3: bits above the configured width read zero
   p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((data >> nbits) == '0));

endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk #(
   parameter int DIV_W       = 12,
   parameter int OVS         = 16,
   parameter int DATA_MAX    = 8,
   parameter int LEN_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DIV_W-1:0]    baud_div,
   input  logic [LEN_W-1:0]    len_sel,
   input  logic                par_en,
   input  logic                par_odd,
   input  logic                stop_two,
   input  logic                rx_line,
   output logic [DATA_MAX-1:0] rx_data,
   output logic                rx_valid,
   output logic                rx_par_err,
   output logic                rx_frm_err,
   output logic                rx_break
);

   logic tick;
   logic rx_s;

   srx_tick_gen #(
      .DIV_W (DIV_W)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .div   (baud_div),
      .tick  (tick)
   );

   srx_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_line),
      .q     (rx_s)
   );

   srx_frame_fsm #(
      .OVS      (OVS),
      .DATA_MAX (DATA_MAX),
      .LEN_W    (LEN_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .rx_s     (rx_s),
      .len_sel  (len_sel),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .stop_two (stop_two),
      .data     (rx_data),
      .valid    (rx_valid),
      .par_err  (rx_par_err),
      .frm_err  (rx_frm_err),
      .brk      (rx_break)
   );

endmodule

// File: tb/serial_rx_brk_tb.sv
`timescale 1ns/1ps
module serial_rx_brk_tb;

   logic        clk;
   logic        rst_n;
   logic [11:0] baud_div;
   logic [1:0]  len_sel;
   logic        par_en;
   logic        par_odd;
   logic        stop_two;
   logic        rx_line;
   logic [7:0]  rx_data;
   logic        rx_valid;
   logic        rx_par_err;
   logic        rx_frm_err;
   logic        rx_break;

   int checks   = 0;
   int failures = 0;
   int vcount   = 0;
   int cyc      = 0;
   int t_valid  = 0;
   bit finished = 0;
   logic [7:0] l_data;
   logic       l_perr, l_ferr, l_brk;

   serial_rx_brk u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .baud_div   (baud_div),
      .len_sel    (len_sel),
      .par_en     (par_en),
      .par_odd    (par_odd),
      .stop_two   (stop_two),
      .rx_line    (rx_line),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .rx_par_err (rx_par_err),
      .rx_frm_err (rx_frm_err),
      .rx_break   (rx_break)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rx_valid) begin
         vcount  <= vcount + 1;
         l_data  <= rx_data;
         l_perr  <= rx_par_err;
         l_ferr  <= rx_frm_err;
         l_brk   <= rx_break;
         t_valid <= cyc;
      end
   end

   // {div[3:0], len_sel[1:0], par_en, par_odd, stop_two, bad_par, bad_stop, data[7:0]}
   localparam int NV = 12;
   localparam logic [18:0] VEC [NV] = '{
      {4'd4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
      {4'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C},
      {4'd2, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h81},
      {4'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1B},
      {4'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF},
      {4'd2, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h55},
      {4'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h6E},
      {4'd2, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h12},
      {4'd2, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h12},
      {4'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h40},
      {4'd5, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01},
      {4'd7, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic hold(input logic v, input int n);
      rx_line = v;
      repeat (n) @(negedge clk);
   endtask

   function automatic int bitclks(input int div);
      return 16 * ((div == 0) ? 1 : div);
   endfunction

   task automatic send(input int div, input int ls, input bit pe, input bit po,
                       input bit two, input bit bp, input bit bs, input bit s2low,
                       input logic [7:0] d);
      int bc;
      int nb;
      logic [7:0] m;
      logic p;
      bc = bitclks(div);
      nb = 5 + ls;
      m  = 8'((1 << nb) - 1);
      baud_div = 12'(div);
      len_sel  = 2'(ls);
      par_en   = pe;
      par_odd  = po;
      stop_two = two;
      hold(1'b1, bc);
      hold(1'b0, bc);
      for (int i = 0; i < nb; i++) hold(d[i], bc);
      if (pe) begin
         p = (^(d & m)) ^ po ^ bp;
         hold(p, bc);
      end
      hold(!bs, bc);
      if (two) hold(!s2low, bc);
      hold(1'b1, 3 * bc);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int base;
      rst_n    = 1'b0;
      rx_line  = 1'b1;
      baud_div = 12'd4;
      len_sel  = 2'd3;
      par_en   = 1'b0;
      par_odd  = 1'b0;
      stop_two = 1'b0;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk("R1 valid", int'(rx_valid), 0);
      chk("R1 flags", int'({rx_par_err, rx_frm_err, rx_break}), 0);
      rst_n = 1'b1;
      repeat (200) @(negedge clk);
      chk("R1 idle-no-char", vcount, 0);

      // R3 R4 R5 R9: vector walk
      for (int k = 0; k < NV; k++) begin
         logic [18:0] v;
         int div;
         int ls;
         logic [7:0] m;
         v    = VEC[k];
         div  = int'(v[18:15]);
         ls   = int'(v[14:13]);
         m    = 8'((1 << (5 + ls)) - 1);
         base = vcount;
         send(div, ls, v[12], v[11], v[10], v[9], v[8], 1'b0, v[7:0]);
         chk("R7 one-strobe", vcount - base, 1);
         chk("R3 data", int'(l_data), int'(v[7:0] & m));
         chk("R4 parity", int'(l_perr), int'(v[12] & v[9]));
         chk("R5 framing", int'(l_ferr), int'(v[8]));
         chk("R6 no-break", int'(l_brk), 0);
      end

      // R2: short low pulse rejected
      baud_div = 12'd4;
      len_sel  = 2'd3;
      par_en   = 1'b0;
      stop_two = 1'b0;
      base = vcount;
      hold(1'b1, 64);
      hold(1'b0, 20);
      hold(1'b1, 64 * 12);
      chk("R2 glitch-ignored", vcount - base, 0);
      send(4, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC3);
      chk("R2 recover-count", vcount - base, 1);
      chk("R2 recover-data", int'(l_data), 8'hC3);

      // R6: long low is a break, reported once
      base = vcount;
      baud_div = 12'd2;
      hold(1'b1, 32);
      hold(1'b0, 32 * 14);
      chk("R6 break-count", vcount - base, 1);
      chk("R6 break-flag", int'(l_brk), 1);
      chk("R6 break-data", int'(l_data), 0);
      chk("R6 break-frm", int'(l_ferr), 0);
      hold(1'b1, 32 * 3);
      chk("R6 no-repeat", vcount - base, 1);
      send(2, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h7E);
      chk("R6 after-break-data", int'(l_data), 8'h7E);
      chk("R6 after-break-flag", int'(l_brk), 0);

      // R6: low for exactly one frame is a framing error, not a break
      base = vcount;
      baud_div = 12'd8;
      hold(1'b1, 128);
      hold(1'b0, 128 * 10);
      hold(1'b1, 128 * 3);
      chk("R6 short-low-count", vcount - base, 1);
      chk("R6 short-low-brk", int'(l_brk), 0);
      chk("R6 short-low-frm", int'(l_ferr), 1);
      chk("R6 short-low-data", int'(l_data), 0);

      // R8: second stop low is ignored
      base = vcount;
      send(3, 3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A);
      chk("R8 count", vcount - base, 1);
      chk("R8 data", int'(l_data), 8'h5A);
      chk("R8 frm", int'(l_ferr), 0);

      // R9: latency from start edge to strobe follows the divisor
      begin
         int t0;
         baud_div = 12'd3;
         len_sel  = 2'd3;
         par_en   = 1'b0;
         stop_two = 1'b0;
         hold(1'b1, 48);
         t0 = cyc;
         hold(1'b0, 48);
         for (int i = 0; i < 8; i++) hold(1'b1, 48);
         hold(1'b1, 48 * 3);
         chk("R9 data", int'(l_data), 8'hFF);
         chk("R9 latency-low", int'((t_valid - t0) >= 455), 1);
         chk("R9 latency-high", int'((t_valid - t0) <= 468), 1);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule